// File: doc/BRIEF.md
# Radix Page-Table Walker

This block turns a 64-bit virtual address into a physical frame number by walking a six-level radix translation tree kept in memory. With 4 KiB pages the low 12 address bits are the page offset. The remaining 52 bits form the page number. Each table entry is 4 bytes, so every table page holds 1024 entries and each level consumes 10 index bits. The top level takes only the 2 leftover high bits. A walk therefore costs at most six sequential memory reads.

The requester pulses `start` with the address and the physical base of the root table. The walker then issues one read per level over a valid/ready request channel and waits for each response before it moves on. Each entry either points to the next table or, at the last level, names the frame. A cleared present bit at any level stops the walk with a fault. Completion is signalled by a one-cycle `done` pulse, with the frame number or the fault flag held on the outputs.

Top module: `page_walker`

## Requirements
- R1: While and after reset, `busy`, `done` and `memReqValid` are 0.
- R2: Levels go from most to least significant. Level 0 indexes with VA bits 63:62. Level k (1 to 5) indexes with VA bits [12+10*(5-k)+9 : 12+10*(5-k)]. The read address is the current table base plus 4 times the index.
- R3: The first table base is `rootBase`, captured at start. After a present entry, the next base is entry bits 31:12 shifted left by 12. Entry bits 11:1 are ignored.
- R4: Entry bit 0 is the present bit. If it is 0 at any level, the walk ends at once with `fault`=1 and no further read is issued.
- R5: A walk with all entries present makes exactly six reads. It ends with `fault`=0 and `frame` equal to bits 31:12 of the sixth entry.
- R6: A request holds `memReqValid` and `memReqAddr` stable until `memReqReady`. Only one read is outstanding at a time. The next request appears only after the response has arrived.
- R7: `done` is a one-cycle pulse in the cycle after the final response is accepted. `busy` drops in that same cycle, and `busy` stays high with no `done` between levels.
- R8: A `start` raised while `busy` is 1 is ignored, and the walk in progress keeps its original address and root.
- R9: When `fault` is reported, `frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 64 | Virtual address to translate |
| rootBase | input | 32 | Physical base of the top-level table |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Last walk hit a non-present entry |
| frame | output | 20 | Translated frame number |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry read from memory |

## Verification
Walks are run with address patterns of all zeros, all ones, alternating bits, and a marked 10-bit field at each level position in turn. These patterns show whether each level picks its own index field, or a neighbouring one, or the wrong width. Every address is paired with a fault placed at each of the six levels, and with no fault at all. This separates early termination, the point at which a fault is seen, and leaf frame extraction. Request and response latencies of zero to two cycles show whether the request is held stable and whether the single outstanding read is kept. A start pulse injected mid-walk shows whether a busy walker ignores new requests.

// File: rtl/page_walker_pkg.sv
package page_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT
  } walkState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture address and root, restart at level 0
    logic advance;  // follow the entry to the next level
    logic finish;   // latch the result of the walk
  } walkStrobes_t;

endpackage

// File: rtl/page_walker_ctrl.sv
module page_walker_ctrl
  import page_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         lastLevel,
  input  logic         entryPresent,
  output walkStrobes_t strb,
  output logic         memReqValid,
  output logic         busy,
  output logic         done
);

  walkState_t stateQ, stateD;
  logic doneQ;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateD    = ST_REQ;
        end
      end
      ST_REQ: begin
        if (memReqReady) stateD = ST_WAIT;
      end
      ST_WAIT: begin
        if (memRspValid) begin
          if (!entryPresent || lastLevel) begin
            strb.finish = 1'b1;
            stateD      = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            stateD       = ST_REQ;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.finish;
    end
  end

  assign memReqValid = (stateQ == ST_REQ);
  assign busy        = (stateQ != ST_IDLE);
  assign done        = doneQ;

endmodule

// File: rtl/page_walker_dp.sv
module page_walker_dp
  import page_walker_pkg::*;
#(
  parameter int VA_W    = 64,
  parameter int PAGE_W  = 12,
  parameter int IDX_W   = 10,
  parameter int PTE_W   = 32,
  parameter int PA_W    = 32,
  parameter int LEVELS  = 6,
  parameter int LVL_W   = 3,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  walkStrobes_t       strb,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [PA_W-1:0]    rootBase,
  input  logic [PTE_W-1:0]   memRspData,
  output logic [PA_W-1:0]    memReqAddr,
  output logic               lastLevel,
  output logic               entryPresent,
  output logic               fault,
  output logic [FRAME_W-1:0] frame
);

  localparam int VPN_W    = VA_W - PAGE_W;
  localparam int PAD_W    = LEVELS * IDX_W;
  localparam int ENTRY_SH = $clog2(PTE_W / 8);

  logic [PAD_W-1:0]   vpnQ;
  logic [PA_W-1:0]    baseQ;
  logic [LVL_W-1:0]   levelQ;
  logic               faultQ;
  logic [FRAME_W-1:0] frameQ;

  logic [IDX_W-1:0]   idxArr [LEVELS];
  logic [IDX_W-1:0]   curIdx;
  logic [FRAME_W-1:0] entryFrame;
  logic [PA_W-1:0]    nextBase;

  // Bits that play no part in translation
  logic unusedBits;
  assign unusedBits = ^{vaddr[PAGE_W-1:0], memRspData[PAGE_W-1:1]};

  // One index field per level, most significant level first
  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idxArr[l] = vpnQ[(LEVELS-1-l)*IDX_W +: IDX_W];
  end

  assign curIdx       = idxArr[levelQ];
  assign memReqAddr   = baseQ + (PA_W'(curIdx) << ENTRY_SH);
  assign lastLevel    = (levelQ == LVL_W'(LEVELS-1));
  assign entryPresent = memRspData[0];
  assign entryFrame   = memRspData[PAGE_W +: FRAME_W];
  assign nextBase     = {entryFrame, {PAGE_W{1'b0}}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpnQ   <= '0;
      baseQ  <= '0;
      levelQ <= '0;
      faultQ <= 1'b0;
      frameQ <= '0;
    end else begin
      if (strb.load) begin
        vpnQ   <= PAD_W'(vaddr[VA_W-1:VA_W-VPN_W]);
        baseQ  <= rootBase;
        levelQ <= '0;
      end
      if (strb.advance) begin
        baseQ  <= nextBase;
        levelQ <= levelQ + 1'b1;
      end
      if (strb.finish) begin
        faultQ <= !entryPresent;
        frameQ <= entryPresent ? entryFrame : '0;
      end
    end
  end

  assign fault = faultQ;
  assign frame = frameQ;

endmodule

// File: rtl/page_walker.sv
module page_walker
  import page_walker_pkg::*;
#(
  parameter int VA_W   = 64,
  parameter int PAGE_W = 12,
  parameter int IDX_W  = 10,
  parameter int PTE_W  = 32,
  parameter int PA_W   = 32,
  localparam int LEVELS  = (VA_W - PAGE_W + IDX_W - 1) / IDX_W,
  localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int FRAME_W = PA_W - PAGE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [VA_W-1:0]    vaddr,
  input  logic [PA_W-1:0]    rootBase,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [FRAME_W-1:0] frame,
  output logic               memReqValid,
  input  logic               memReqReady,
  output logic [PA_W-1:0]    memReqAddr,
  input  logic               memRspValid,
  input  logic [PTE_W-1:0]   memRspData
);

  walkStrobes_t strb;
  logic lastLevel;
  logic entryPresent;

  page_walker_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .memReqReady  (memReqReady),
    .memRspValid  (memRspValid),
    .lastLevel    (lastLevel),
    .entryPresent (entryPresent),
    .strb         (strb),
    .memReqValid  (memReqValid),
    .busy         (busy),
    .done         (done)
  );

  page_walker_dp #(
    .VA_W    (VA_W),
    .PAGE_W  (PAGE_W),
    .IDX_W   (IDX_W),
    .PTE_W   (PTE_W),
    .PA_W    (PA_W),
    .LEVELS  (LEVELS),
    .LVL_W   (LVL_W),
    .FRAME_W (FRAME_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .vaddr        (vaddr),
    .rootBase     (rootBase),
    .memRspData   (memRspData),
    .memReqAddr   (memReqAddr),
    .lastLevel    (lastLevel),
    .entryPresent (entryPresent),
    .fault        (fault),
    .frame        (frame)
  );

endmodule

// File: rtl/page_walker_checker.sv
module page_walker_checker #(
  parameter int PA_W    = 32,
  parameter int FRAME_W = 20,
  parameter int LEVELS  = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fault,
  input logic [FRAME_W-1:0] frame,
  input logic               memReqValid,
  input logic               memReqReady,
  input logic [PA_W-1:0]    memReqAddr,
  input logic               memRspValid
);

  // Reads accepted since the current walk began
  logic [7:0] readCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readCnt <= '0;
    else if (start && !busy) readCnt <= '0;
    else if (memReqValid && memReqReady) readCnt <= readCnt + 8'd1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReqValid);

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));

  assert_one_outstanding_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && memReqReady |=> !memReqValid);

  assert_read_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    readCnt <= 8'(LEVELS));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_ends_walk_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_fault_frame_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    done && fault |-> frame == '0);

  // Response channel is unused by these checks beyond documentation of intent
  logic unusedRsp;
  assign unusedRsp = memRspValid;

endmodule

bind page_walker page_walker_checker #(
  .PA_W    (PA_W),
  .FRAME_W (FRAME_W),
  .LEVELS  (LEVELS)
) walkChk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .fault       (fault),
  .frame       (frame),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .memRspValid (memRspValid)
);

// File: tb/tb_page_walker.sv
module tb_page_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] vaddr = '0;
  logic [31:0] rootBase = '0;
  logic        busy, done, fault;
  logic [19:0] frame;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  page_walker dut (
    .clk(clk), .rstN(rstN), .start(start), .vaddr(vaddr), .rootBase(rootBase),
    .busy(busy), .done(done), .fault(fault), .frame(frame),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Index used at a level: level 0 takes VA[63:62], others 10-bit fields
  function automatic logic [31:0] idxOf(input logic [63:0] va, input int lvl);
    return 32'((va >> (12 + 10 * (5 - lvl))) & 64'h3FF);
  endfunction

  // Memory contents computed from address and level; junk in bits 11:1
  function automatic logic [31:0] makeEntry(input logic [31:0] addr, input int lvl,
                                            input int faultLvl);
    logic [31:0] f;
    f = (addr >> 2) * 32'd13 + 32'(lvl) * 32'h2F1 + 32'h55;
    return {f[19:0], 11'h3A5, (lvl != faultLvl)};
  endfunction

  task automatic runWalk(input logic [63:0] va, input logic [31:0] root,
                         input int faultLvl, input int lat, input bit poke);
    logic [31:0] base, expAddr, entry;
    logic [19:0] fr;
    int w;
    base = root;
    @(negedge clk);
    start = 1'b1; vaddr = va; rootBase = root;
    @(negedge clk);
    start = 1'b0; vaddr = ~va; rootBase = ~root;
    chk(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    for (int lvl = 0; lvl < 6; lvl++) begin
      w = 0;
      while (!memReqValid && w < 50) begin @(negedge clk); w++; end
      expAddr = base + idxOf(va, lvl) * 32'd4;
      chk(memReqValid == 1'b1, "R6", "request present", 64'(memReqValid), 64'd1);
      chk(memReqAddr == expAddr, (lvl == 0) ? "R2" : "R3", "entry address",
          64'(memReqAddr), 64'(expAddr));
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(memReqValid && memReqAddr == expAddr, "R6", "request held",
            64'(memReqAddr), 64'(expAddr));
      end
      if (poke && lvl == 2) begin
        start = 1'b1; vaddr = 64'hFFFF_0000_FFFF_0000; rootBase = 32'h0BAD_0000;
        @(negedge clk);
        start = 1'b0;
        chk(memReqAddr == expAddr, "R8", "start while busy ignored",
            64'(memReqAddr), 64'(expAddr));
      end
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      chk(memReqValid == 1'b0, "R6", "no second outstanding read", 64'(memReqValid), 64'd0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(memReqValid == 1'b0, "R6", "no request before response", 64'(memReqValid), 64'd0);
      end
      entry = makeEntry(expAddr, lvl, faultLvl);
      fr = entry[31:12];
      memRspValid = 1'b1; memRspData = entry;
      @(negedge clk);
      memRspValid = 1'b0; memRspData = 32'hDEAD_BEEE;
      if (lvl == faultLvl) begin
        chk(done == 1'b1, "R7", "done after faulting response", 64'(done), 64'd1);
        chk(fault == 1'b1, "R4", "fault on clear present bit", 64'(fault), 64'd1);
        chk(frame == 20'd0, "R9", "frame zero on fault", 64'(frame), 64'd0);
        @(negedge clk);
        chk(!done && !busy, "R7", "done single pulse", 64'({done, busy}), 64'd0);
        chk(memReqValid == 1'b0, "R4", "no read after fault", 64'(memReqValid), 64'd0);
        return;
      end else if (lvl == 5) begin
        chk(done == 1'b1, "R7", "done after leaf", 64'(done), 64'd1);
        chk(busy == 1'b0, "R7", "busy drops with done", 64'(busy), 64'd0);
        chk(fault == 1'b0, "R5", "no fault on full walk", 64'(fault), 64'd0);
        chk(frame == fr, "R5", "leaf frame", 64'(frame), 64'(fr));
        @(negedge clk);
        chk(!done && !memReqValid, "R5", "walk ends after six reads",
            64'({done, memReqValid}), 64'd0);
        return;
      end else begin
        chk(!done && busy, "R7", "no done between levels", 64'({done, busy}), 64'b01);
        base = {fr, 12'h000};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] pats [10];
    logic [31:0] roots [2];
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'hAAAA_AAAA_AAAA_AAAA;
    pats[3] = 64'h5555_5555_5555_5555;
    for (int k = 0; k < 6; k++) pats[4 + k] = (64'h3FF << (12 + 10 * k)) ^ 64'h123;
    roots[0] = 32'h0001_0000;
    roots[1] = 32'hFFFF_F000;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1", "outputs in reset",
        64'({busy, done, memReqValid}), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1", "outputs after reset",
        64'({busy, done, memReqValid}), 64'd0);

    for (int p = 0; p < 10; p++)
      for (int f = 0; f <= 6; f++)
        for (int l = 0; l < 3; l++)
          runWalk(pats[p], roots[(p + f) % 2], f, l, (f == 6) && (l == 1));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule